// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the destination address at the head of each received Ethernet frame and decides whether the frame is kept or dropped. The frame arrives one byte per cycle between a start strobe and an end strobe. The first six bytes form the destination address. Within each byte, bit 0 is the first bit on the wire.

The block checks the address in three ways. It compares the address with a programmed station address, and can mask the final four address bits so that a group of sixteen stations matches. It recognises the all-ones broadcast address. For multicast frames it can index a 64-bit hash table with six bits of a CRC-32 computed over the address bytes. A length rule optionally rejects runt frames. The verdict appears as a one-cycle strobe with an accept flag, plus a flag that marks acceptance that came from the hash table alone.

Top module: `rxAddrFilter`

## Requirements
- R1: After reset `decisionValid`, `accept` and `hashHit` are 0. Each `frameEnd` inside a frame produces exactly one `decisionValid` pulse, in the cycle after the `frameEnd` cycle. While `decisionValid` is 0, `accept` and `hashHit` are 0.
- R2: Address byte k (the k-th received byte, k = 0..5) is compared with `stationAddr[8k+7:8k]`. With `matchMode` = 0, a frame whose six address bytes all equal the station address is accepted, and a frame that differs in any compared bit is rejected.
- R3: With `groupMode` = 1, the last four address bits on the wire (bits 7:4 of byte 5, compared against `stationAddr[47:44]`) take no part in the compare. All other bits still must match.
- R4: The broadcast address (all 48 bits 1) is accepted with `matchMode` 1 or 3 and rejected with `matchMode` 0 unless it equals the station address.
- R5: With `matchMode` = 2, every frame is accepted unless the runt rule rejects it.
- R6: With `matchMode` = 3 and `hashEnable` = 1, a multicast frame (bit 0 of byte 0 is 1) that is neither broadcast nor a station match is handled by the hash table. The frame is accepted, with `hashHit` = 1, exactly when bit `idx` of `hashTable` is 1. Here `idx` is bits 5:0 of the CRC shift register after the 48 address bits. That register uses the reflected polynomial 0xEDB88320, a preset of all ones, LSB-first input and no final inversion.
- R7: With `matchMode` = 3 and `hashEnable` = 0, every multicast frame is accepted and `hashHit` is 0.
- R8: With `runtReject` = 1, a frame of fewer than 13 bytes is rejected in every mode, and a frame of 13 or more bytes is decided normally. With `runtReject` = 0, the length has no effect.
- R9: A `frameStart` clears all per-frame state, so a new frame is filtered independently. This also holds when the strobe arrives before the previous frame ended.
- R10: A `frameEnd` outside a frame (no `frameStart` since the last decision) produces no decision.
- R11: A frame with fewer than six bytes never matches the station, broadcast or multicast rules. Only `matchMode` 2 accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| frameStart | input | 1 | Strobe one cycle before the first byte of a frame |
| byteValid | input | 1 | `byteData` holds a received byte |
| byteData | input | 8 | Received byte, bit 0 first on the wire |
| frameEnd | input | 1 | Strobe one cycle after the last byte of a frame |
| stationAddr | input | 48 | Station address, byte k in bits 8k+7:8k |
| hashTable | input | 64 | Multicast accept bit per hash bucket |
| matchMode | input | 2 | 0 station, 1 station+broadcast, 2 all, 3 station+broadcast+multicast |
| hashEnable | input | 1 | Filter multicast through the hash table |
| groupMode | input | 1 | Mask the last four address bits in the compare |
| runtReject | input | 1 | Reject frames shorter than 13 bytes |
| decisionValid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame is kept |
| hashHit | output | 1 | Frame was kept only through the hash table |

## Verification
The bench builds the block with its default parameters: six address bytes, a 13-byte runt limit, a 64-entry hash table and a 6-bit saturating byte counter. Under those values, frames of 12 and 13 bytes sit on either side of the runt limit. A frame of 80 bytes drives the counter into saturation, so the bench can show that saturation does not turn a long frame into a runt. The bench derives the hash index of its multicast address from its own CRC model and loads either that single bucket or every other bucket. This exercises both the hit and the miss paths.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  typedef struct packed {
    logic clear;
    logic take;
    logic decide;
  } filtStrobe_t;

  typedef struct packed {
    logic isShort;
    logic addrDone;
    logic stationHit;
    logic bcastHit;
    logic mcastBit;
    logic hashBit;
  } filtStatus_t;
endpackage

// File: rtl/rxaf_datapath.sv
module rxaf_datapath
  import rxaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int RUNT_LEN   = 13,
  parameter int CNT_W      = 6,
  parameter int HASH_W     = 64,
  parameter int GROUP_BITS = 4,
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  filtStrobe_t               stb,
  input  logic [7:0]                byteData,
  input  logic [ADDR_BYTES*8-1:0]   stationAddr,
  input  logic [HASH_W-1:0]         hashTable,
  input  logic                      groupMode,
  output filtStatus_t               status
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int IDX_W  = $clog2(HASH_W);

  logic [CNT_W-1:0]  byteCnt;
  logic [31:0]       crcReg;
  logic [ADDR_W-1:0] addrVec;
  logic [ADDR_W-1:0] cmpMask;
  logic              inAddr;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign inAddr = byteCnt < CNT_W'(ADDR_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      byteCnt <= '0;
      crcReg  <= '1;
    end else if (stb.take) begin
      if (byteCnt != '1) byteCnt <= byteCnt + 1'b1;
      if (inAddr) crcReg <= crcStep(crcReg, byteData);
    end
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : gLane
    logic [7:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN || stb.clear) laneQ <= '0;
      else if (stb.take && byteCnt == CNT_W'(i)) laneQ <= byteData;
    end
    assign addrVec[i*8 +: 8] = laneQ;
  end

  always_comb begin
    cmpMask = '1;
    if (groupMode) cmpMask[ADDR_W-1 -: GROUP_BITS] = '0;
  end

  always_comb begin
    status.isShort    = byteCnt < CNT_W'(RUNT_LEN);
    status.addrDone   = !inAddr;
    status.stationHit = !inAddr && (((addrVec ^ stationAddr) & cmpMask) == '0);
    status.bcastHit   = !inAddr && (addrVec == '1);
    status.mcastBit   = !inAddr && addrVec[0];
    status.hashBit    = hashTable[crcReg[IDX_W-1:0]];
  end
endmodule

// File: rtl/rxaf_control.sv
module rxaf_control
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        byteValid,
  input  logic        frameEnd,
  input  logic [1:0]  matchMode,
  input  logic        hashEnable,
  input  logic        runtReject,
  input  filtStatus_t status,
  output filtStrobe_t stb,
  output logic        decisionValid,
  output logic        accept,
  output logic        hashHit
);
  logic inFrame;
  logic lenOk;
  logic addrOk;
  logic hashOnly;
  logic mcastPass;

  always_comb begin
    stb.clear  = frameStart;
    stb.take   = byteValid && inFrame && !frameStart;
    stb.decide = frameEnd && inFrame && !frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          inFrame <= 1'b0;
    else if (frameStart) inFrame <= 1'b1;
    else if (frameEnd)   inFrame <= 1'b0;
  end

  always_comb begin
    lenOk     = !(runtReject && status.isShort);
    mcastPass = status.mcastBit && (!hashEnable || status.hashBit);
    hashOnly  = 1'b0;
    unique case (matchMode)
      2'd0: addrOk = status.stationHit;
      2'd1: addrOk = status.stationHit || status.bcastHit;
      2'd2: addrOk = 1'b1;
      default: begin
        addrOk   = status.stationHit || status.bcastHit || mcastPass;
        hashOnly = hashEnable && status.mcastBit && status.hashBit &&
                   !status.stationHit && !status.bcastHit;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decisionValid <= 1'b0;
      accept        <= 1'b0;
      hashHit       <= 1'b0;
    end else begin
      decisionValid <= stb.decide;
      accept        <= stb.decide && lenOk && addrOk;
      hashHit       <= stb.decide && lenOk && hashOnly;
    end
  end
endmodule

// File: rtl/rxAddrFilter.sv
module rxAddrFilter
  import rxaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int RUNT_LEN   = 13,
  parameter int CNT_W      = 6,
  parameter int HASH_W     = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStart,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  input  logic                    frameEnd,
  input  logic [ADDR_BYTES*8-1:0] stationAddr,
  input  logic [HASH_W-1:0]       hashTable,
  input  logic [1:0]              matchMode,
  input  logic                    hashEnable,
  input  logic                    groupMode,
  input  logic                    runtReject,
  output logic                    decisionValid,
  output logic                    accept,
  output logic                    hashHit
);
  filtStrobe_t stb;
  filtStatus_t status;

  rxaf_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .RUNT_LEN(RUNT_LEN), .CNT_W(CNT_W), .HASH_W(HASH_W)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .byteData(byteData),
    .stationAddr(stationAddr), .hashTable(hashTable), .groupMode(groupMode),
    .status(status)
  );

  rxaf_control ctl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .frameEnd(frameEnd), .matchMode(matchMode), .hashEnable(hashEnable),
    .runtReject(runtReject), .status(status), .stb(stb),
    .decisionValid(decisionValid), .accept(accept), .hashHit(hashHit)
  );
endmodule

// File: rtl/rxAddrFilter_chk.sv
module rxAddrFilter_chk #(
  parameter int RUNT_LEN = 13
) (
  input logic       clk,
  input logic       rstN,
  input logic       frameStart,
  input logic       byteValid,
  input logic       frameEnd,
  input logic [1:0] matchMode,
  input logic       hashEnable,
  input logic       runtReject,
  input logic       decisionValid,
  input logic       accept,
  input logic       hashHit
);
  logic [7:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN || frameStart) seen <= '0;
    else if (byteValid && seen != 8'hFF) seen <= seen + 1'b1;
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid);
  a_r1_after_end: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |-> $past(frameEnd));
  a_r10_quiet_flags: assert property (@(posedge clk) disable iff (!rstN)
    !decisionValid |-> (!accept && !hashHit));
  a_r6_hash_mode: assert property (@(posedge clk) disable iff (!rstN)
    hashHit |-> (accept && $past(matchMode) == 2'd3 && $past(hashEnable)));
  a_r8_runt_drop: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && $past(runtReject) && $past(seen < 8'(RUNT_LEN))) |-> !accept);
  a_r5_accept_all: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && $past(matchMode) == 2'd2 && !$past(runtReject)) |-> accept);
endmodule

bind rxAddrFilter rxAddrFilter_chk #(.RUNT_LEN(RUNT_LEN)) chk (.*);

// File: tb/rxAddrFilter_test.sv
`timescale 1ns/1ps
module rxAddrFilter_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        frameStart, byteValid, frameEnd;
  logic [7:0]  byteData;
  logic [47:0] stationAddr;
  logic [63:0] hashTable;
  logic [1:0]  matchMode;
  logic        hashEnable, groupMode, runtReject;
  logic        decisionValid, accept, hashHit;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [47:0] STA   = 48'hA5_44_33_22_11_02;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

  always #2.5 clk = ~clk;

  rxAddrFilter uut (.*);

  function automatic logic [5:0] hashIdx(input logic [47:0] a);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c[5:0];
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {valid,accept,hashHit} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic sendBytes(input logic [47:0] a, input int len);
    for (int i = 0; i < len; i++) begin
      byteValid = 1'b1;
      byteData  = (i < 6) ? a[i*8 +: 8] : (8'(i) ^ 8'h5A);
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic runFrame(input string req, input logic [47:0] a, input int len,
                          input logic expAcc, input logic expHash);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    sendBytes(a, len);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    check(req, {decisionValid, accept, hashHit}, {1'b1, expAcc, expHash});
    @(negedge clk);
  endtask

  task automatic setMode(input logic [1:0] m, input logic he, input logic gm, input logic rr);
    matchMode = m; hashEnable = he; groupMode = gm; runtReject = rr;
  endtask

  task automatic testReset();
    check("R1 reset", {decisionValid, accept, hashHit}, 3'b000);
  endtask

  task automatic testStation();
    setMode(2'd0, 0, 0, 0);
    runFrame("R2 exact match", STA, 20, 1, 0);
    runFrame("R2 byte2 differs", STA ^ 48'h0000_0001_0000, 20, 0, 0);
    frameStart = 1'b1; @(negedge clk); frameStart = 1'b0;
    sendBytes(STA, 20);
    frameEnd = 1'b1; @(negedge clk); frameEnd = 1'b0;
    @(negedge clk);
    check("R1 pulse is one cycle", {decisionValid, accept, hashHit}, 3'b000);
  endtask

  task automatic testGroup();
    setMode(2'd0, 0, 1, 0);
    runFrame("R3 masked nibble differs", {8'h35, STA[39:0]}, 20, 1, 0);
    runFrame("R3 bit 40 still compared", {8'hA4, STA[39:0]}, 20, 0, 0);
    setMode(2'd0, 0, 0, 0);
    runFrame("R3 group off nibble compared", {8'h35, STA[39:0]}, 20, 0, 0);
  endtask

  task automatic testBroadcast();
    setMode(2'd0, 0, 0, 0);
    runFrame("R4 broadcast mode0", BCAST, 20, 0, 0);
    setMode(2'd1, 0, 0, 0);
    runFrame("R4 broadcast mode1", BCAST, 20, 1, 0);
    setMode(2'd3, 1, 0, 0);
    hashTable = '0;
    runFrame("R4 broadcast mode3 ignores hash", BCAST, 20, 1, 0);
  endtask

  task automatic testAll();
    setMode(2'd2, 0, 0, 0);
    runFrame("R5 foreign unicast", 48'h12_34_56_78_9A_BC, 20, 1, 0);
  endtask

  task automatic testHash();
    logic [5:0] idx;
    idx = hashIdx(MCAST);
    setMode(2'd3, 1, 0, 0);
    hashTable = 64'd1 << idx;
    runFrame("R6 hash hit", MCAST, 20, 1, 1);
    hashTable = ~(64'd1 << idx);
    runFrame("R6 hash miss", MCAST, 20, 0, 0);
    runFrame("R6 station beats hash", STA, 20, 1, 0);
    setMode(2'd3, 0, 0, 0);
    runFrame("R7 hash disabled", MCAST, 20, 1, 0);
    runFrame("R7 unicast foreign", 48'h12_34_56_78_9A_BC, 20, 0, 0);
  endtask

  task automatic testRunt();
    setMode(2'd0, 0, 0, 1);
    runFrame("R8 12 bytes dropped", STA, 12, 0, 0);
    runFrame("R8 13 bytes kept", STA, 13, 1, 0);
    runFrame("R8 80 bytes kept", STA, 80, 1, 0);
    setMode(2'd2, 0, 0, 1);
    runFrame("R8 runt mode2 dropped", STA, 5, 0, 0);
    setMode(2'd0, 0, 0, 0);
    runFrame("R8 rule off 12 bytes", STA, 12, 1, 0);
  endtask

  task automatic testRestart();
    setMode(2'd0, 0, 0, 0);
    frameStart = 1'b1; @(negedge clk); frameStart = 1'b0;
    sendBytes(48'h12_34_56_78_9A_BC, 9);
    check("R9 no verdict mid-frame", {decisionValid, accept, hashHit}, 3'b000);
    runFrame("R9 restarted frame", STA, 14, 1, 0);
    runFrame("R9 next frame independent", BCAST, 14, 0, 0);
  endtask

  task automatic testStray();
    frameEnd = 1'b1; @(negedge clk); frameEnd = 1'b0;
    check("R10 stray end", {decisionValid, accept, hashHit}, 3'b000);
  endtask

  task automatic testShort();
    setMode(2'd0, 0, 0, 0);
    runFrame("R11 4-byte prefix match", STA, 4, 0, 0);
    setMode(2'd3, 0, 0, 0);
    runFrame("R11 short multicast", MCAST, 3, 0, 0);
    setMode(2'd2, 0, 0, 0);
    runFrame("R11 short mode2", STA, 4, 1, 0);
  endtask

  initial begin
    rstN = 1'b0; frameStart = 0; byteValid = 0; frameEnd = 0; byteData = '0;
    stationAddr = STA; hashTable = '0;
    setMode(2'd0, 0, 0, 0);
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStation();
    testGroup();
    testBroadcast();
    testAll();
    testHash();
    testRunt();
    testRestart();
    testStray();
    testShort();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule